// File: doc/BRIEF.md
# Power-Down Inactivity Timer with Host Interrupt

This block measures idle time and reports a power-down timeout. A prescaler turns the system clock into coarse time units. A unit counter then counts a selectable number of those units. When the chosen interval has passed without an activity-restart strobe, the block sets a sticky timeout flag. It also sets a host interrupt status bit. After each expiry the counter starts again from zero, so a card that stays idle produces a timeout event once per interval.

All settings come from one configuration word, written with a single strobe: enable, test mode, interval select, interrupt enable, pulse mode and pin polarity. A test mode replaces the long unit with a short one, so that firmware and benches can exercise the path quickly. The interrupt pin can follow the status bit as a level, or it can give a fixed two-cycle pulse for each event. Either form can be driven active high or active low. This block only decides when a timeout happens; powering down other logic is done elsewhere.

Top module: `pdt_timer`

## Requirements
- R1: After reset, `timeout_sts` and `irq_sts` are 0. The configuration word is all zero, which means active-low polarity, so `irq_pin` sits at 1.
- R2: While the enable bit (configuration bit 0) is 0, no timeout occurs, however long the block waits.
- R3: The interval select (configuration bits 3:2) sets the number of units: 00 gives 16, 01 gives 8, 10 gives 4 and 11 gives 2. Counting starts at the configuration write. `timeout_sts` reads 1 exactly units × unit-length clock cycles after that write edge.
- R4: When the test bit (configuration bit 1) is 0, one unit lasts `UNIT_CLKS` cycles (32,000,000 by default). When it is 1, one unit lasts `TEST_CLKS` cycles (32 by default).
- R5: An activity-restart strobe clears the elapsed time. Any configuration write does the same. The next timeout then comes one full interval after the strobe.
- R6: `timeout_sts` stays 1 until a `sts_clr` strobe clears it. If an expiry falls in the same cycle as the clear, the expiry wins and the flag stays 1.
- R7: `irq_sts` is set on every expiry, whatever the interrupt enable (bit 4) says. Only an `irq_clr` strobe clears it. With the enable at 0, `irq_pin` stays inactive.
- R8: In level mode (bit 5 = 0), the pin is active whenever `irq_sts` and the interrupt enable are both 1.
- R9: In pulse mode (bit 5 = 1), with the enable set, the pin is active for exactly 2 cycles after each expiry. It is then inactive, even while `irq_sts` remains 1.
- R10: The polarity bit (bit 6) selects the active pin level: 1 means active high, 0 means active low.
- R11: After an expiry, counting continues from zero. The next expiry comes one full interval later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe; also restarts the count |
| cfg_wdata | input | 7 | Configuration word: [0] enable, [1] test, [3:2] interval select, [4] interrupt enable, [5] pulse mode, [6] active high |
| sts_clr | input | 1 | Write-one-to-clear strobe for the timeout flag |
| irq_clr | input | 1 | Write-one-to-clear strobe for the interrupt status bit |
| restart | input | 1 | Activity-restart strobe |
| timeout_sts | output | 1 | Sticky timeout flag |
| irq_sts | output | 1 | Host interrupt status bit for the timeout source |
| irq_pin | output | 1 | Interrupt output, polarity and mode as configured |

## Verification
If the prescaler or the unit counter holds a wrong value, the timeout moves. The bench therefore measures the exact cycle on which `timeout_sts` rises, for every select code in both unit lengths, and an off-by-one shows as a count error on that same edge. A pulse-length counter left in a wrong state shows on `irq_pin` within the three cycles after an expiry. A status bit that fails to hold or fails to clear shows on the very next sampled cycle. A restart that does not reach both counters shifts the next timeout by at least one unit.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

    localparam int CFG_W   = 7;
    localparam int UNITS_W = 5;

    typedef struct packed {
        logic       act_high;
        logic       pulse;
        logic       irq_en;
        logic [1:0] sel;
        logic       test;
        logic       en;
    } pdt_cfg_t;

    // Interval select to unit count: 16 >> sel gives 16, 8, 4, 2
    function automatic logic [UNITS_W-1:0] units_for_sel(input logic [1:0] s);
        return UNITS_W'(16) >> s;
    endfunction

    function automatic logic drive_pin(input logic active, input logic high);
        return high ? active : ~active;
    endfunction

endpackage

// File: rtl/pdt_prescaler.sv
module pdt_prescaler #(
    parameter int UNIT_CLKS = 32000000,
    parameter int TEST_CLKS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clr,
    input  logic test,
    output logic tick
);
    localparam int W = (UNIT_CLKS > 2) ? $clog2(UNIT_CLKS) : 1;
    localparam logic [W-1:0] LIM_NORM = W'(UNIT_CLKS - 1);
    localparam logic [W-1:0] LIM_TEST = W'(TEST_CLKS - 1);

    logic [W-1:0] cnt;
    logic [W-1:0] lim;

    assign lim  = test ? LIM_TEST : LIM_NORM;
    assign tick = run && !clr && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || clr || !run) begin
            cnt <= '0;
        end else if (cnt == lim) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pdt_units.sv
module pdt_units
    import pdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       clr,
    input  logic       tick,
    input  logic [1:0] sel,
    output logic       expire
);
    logic [UNITS_W-1:0] cnt;
    logic [UNITS_W-1:0] last;

    assign last   = units_for_sel(sel) - 1'b1;
    assign expire = run && !clr && tick && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || clr || !run) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == last) cnt <= '0;
            else             cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pdt_irq_out.sv
module pdt_irq_out
    import pdt_pkg::*;
#(
    parameter int PULSE_LEN = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      event_in,
    input  logic      irq_clr,
    input  pdt_cfg_t  cfg,
    output logic      irq_sts,
    output logic      irq_act,
    output logic      irq_pin
);
    localparam int PW = $clog2(PULSE_LEN + 1);

    logic [PW-1:0] pcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_sts <= 1'b0;
        end else if (event_in) begin
            irq_sts <= 1'b1;
        end else if (irq_clr) begin
            irq_sts <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
        end else if (event_in && cfg.irq_en) begin
            pcnt <= PW'(PULSE_LEN);
        end else if (pcnt != '0) begin
            pcnt <= pcnt - 1'b1;
        end
    end

    always_comb begin
        if (cfg.pulse) irq_act = (pcnt != '0);
        else           irq_act = irq_sts && cfg.irq_en;
    end

    assign irq_pin = drive_pin(irq_act, cfg.act_high);
endmodule

// File: rtl/pdt_timer.sv
module pdt_timer
    import pdt_pkg::*;
#(
    parameter int UNIT_CLKS = 32000000,
    parameter int TEST_CLKS = 32,
    parameter int PULSE_LEN = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             sts_clr,
    input  logic             irq_clr,
    input  logic             restart,
    output logic             timeout_sts,
    output logic             irq_sts,
    output logic             irq_pin
);
    pdt_cfg_t cfg_q;
    logic     cnt_clr;
    logic     unit_tick;
    logic     expire;
    logic     irq_act;

    assign cnt_clr = restart || cfg_we;

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (cfg_we) cfg_q <= pdt_cfg_t'(cfg_wdata);
    end

    always_ff @(posedge clk) begin
        if (rst)          timeout_sts <= 1'b0;
        else if (expire)  timeout_sts <= 1'b1;
        else if (sts_clr) timeout_sts <= 1'b0;
    end

    pdt_prescaler #(
        .UNIT_CLKS (UNIT_CLKS),
        .TEST_CLKS (TEST_CLKS)
    ) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (cfg_q.en),
        .clr  (cnt_clr),
        .test (cfg_q.test),
        .tick (unit_tick)
    );

    pdt_units u_units (
        .clk    (clk),
        .rst    (rst),
        .run    (cfg_q.en),
        .clr    (cnt_clr),
        .tick   (unit_tick),
        .sel    (cfg_q.sel),
        .expire (expire)
    );

    pdt_irq_out #(
        .PULSE_LEN (PULSE_LEN)
    ) u_irq (
        .clk      (clk),
        .rst      (rst),
        .event_in (expire),
        .irq_clr  (irq_clr),
        .cfg      (cfg_q),
        .irq_sts  (irq_sts),
        .irq_act  (irq_act),
        .irq_pin  (irq_pin)
    );
endmodule

// File: rtl/pdt_timer_chk.sv
module pdt_timer_chk (
    input logic clk,
    input logic rst,
    input logic cfg_we,
    input logic sts_clr,
    input logic timeout_sts,
    input logic irq_sts,
    input logic expire,
    input logic run,
    input logic pulse,
    input logic irq_en,
    input logic irq_act
);
    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !run |-> !expire);

    p_sts_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_sts) |-> $past(expire));

    p_sts_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (timeout_sts && !sts_clr) |=> timeout_sts);

    p_sts_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (sts_clr && !expire) |=> !timeout_sts);

    p_level_r8: assert property (@(posedge clk) disable iff (rst)
        (!pulse && irq_en && irq_sts) |-> irq_act);

    p_pulse_end_r9: assert property (@(posedge clk) disable iff (rst)
        (pulse && !cfg_we && irq_act && $past(irq_act) && !$past(expire) && !expire)
        |=> !irq_act);
endmodule

bind pdt_timer pdt_timer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .sts_clr     (sts_clr),
    .timeout_sts (timeout_sts),
    .irq_sts     (irq_sts),
    .expire      (expire),
    .run         (cfg_q.en),
    .pulse       (cfg_q.pulse),
    .irq_en      (cfg_q.irq_en),
    .irq_act     (irq_act)
);

// File: tb/tb_pdt_timer.sv
`timescale 1ns/1ps
module tb_pdt_timer;
    localparam int UNIT = 100;
    localparam int TUNIT = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [6:0] cfg_wdata = '0;
    logic       sts_clr = 1'b0;
    logic       irq_clr = 1'b0;
    logic       restart = 1'b0;
    logic       timeout_sts, irq_sts, irq_pin;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pdt_timer #(.UNIT_CLKS(UNIT), .TEST_CLKS(TUNIT)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .sts_clr(sts_clr), .irq_clr(irq_clr), .restart(restart),
        .timeout_sts(timeout_sts), .irq_sts(irq_sts), .irq_pin(irq_pin)
    );

    // config bits: 0 en, 1 test, 3:2 sel, 4 irq_en, 5 pulse, 6 act_high
    localparam logic [6:0] EN = 7'h01, TST = 7'h02, IEN = 7'h10, PLS = 7'h20, HI = 7'h40;

    // vector: {test, sel[1:0], expected cycles[15:0]}
    localparam int NV = 6;
    localparam logic [18:0] VEC [NV] = '{
        {1'b1, 2'd0, 16'd512}, {1'b1, 2'd1, 16'd256},
        {1'b1, 2'd2, 16'd128}, {1'b1, 2'd3, 16'd64},
        {1'b0, 2'd3, 16'd200}, {1'b0, 2'd2, 16'd400}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [6:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic clr_all();
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = '0; sts_clr = 1'b1; irq_clr = 1'b1;
        @(negedge clk); cfg_we = 1'b0; sts_clr = 1'b0; irq_clr = 1'b0;
    endtask

    task automatic wait_sts(inout int n, input int limit);
        while (!timeout_sts && n < limit) begin
            @(negedge clk); n++;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(timeout_sts == 0, "R1 timeout_sts", timeout_sts, 0);
        chk(irq_sts == 0, "R1 irq_sts", irq_sts, 0);
        chk(irq_pin == 1, "R1 irq_pin idle", irq_pin, 1);

        // R3/R4 interval table
        for (int i = 0; i < NV; i++) begin
            logic [6:0] c;
            c = EN | (VEC[i][18] ? TST : 7'h00) | {3'b000, VEC[i][17:16], 2'b00};
            wr_cfg(c);
            n = 0;
            wait_sts(n, 3000);
            chk(n == int'(VEC[i][15:0]), "R3 R4 interval", n, int'(VEC[i][15:0]));
            clr_all();
        end

        // R2 disabled: no timeout
        wr_cfg(TST | 7'h0C);
        repeat (300) @(negedge clk);
        chk(timeout_sts == 0, "R2 disabled", timeout_sts, 0);
        clr_all();

        // R5 restart strobe after 40 cycles -> 104 total
        wr_cfg(EN | TST | 7'h0C);
        n = 0;
        repeat (39) begin @(negedge clk); n++; end
        restart = 1'b1;
        @(negedge clk); n++;
        restart = 1'b0;
        wait_sts(n, 1000);
        chk(n == 104, "R5 restart", n, 104);
        clr_all();

        // R6 set wins over clear; R11 periodic re-expiry
        wr_cfg(EN | TST | 7'h0C);
        n = 0;
        repeat (63) begin @(negedge clk); n++; end
        sts_clr = 1'b1;
        @(negedge clk); n++;
        sts_clr = 1'b0;
        chk(timeout_sts == 1, "R6 set wins", timeout_sts, 1);
        repeat (5) begin @(negedge clk); n++; end
        chk(timeout_sts == 1, "R6 sticky", timeout_sts, 1);
        sts_clr = 1'b1;
        @(negedge clk); n++;
        sts_clr = 1'b0;
        chk(timeout_sts == 0, "R6 cleared", timeout_sts, 0);
        wait_sts(n, 1000);
        chk(n == 128, "R11 second expiry", n, 128);
        clr_all();

        // R9 pulse mode, active high
        wr_cfg(EN | TST | 7'h0C | IEN | PLS | HI);
        repeat (63) @(negedge clk);
        chk(irq_pin == 0, "R9 before event", irq_pin, 0);
        @(negedge clk);
        chk(irq_pin == 1, "R9 pulse cycle 1", irq_pin, 1);
        @(negedge clk);
        chk(irq_pin == 1, "R9 pulse cycle 2", irq_pin, 1);
        @(negedge clk);
        chk(irq_pin == 0, "R9 pulse ended", irq_pin, 0);
        chk(irq_sts == 1, "R7 status after pulse", irq_sts, 1);
        clr_all();

        // R8 level mode active high, R7 irq_clr
        wr_cfg(EN | TST | 7'h0C | IEN | HI);
        repeat (64) @(negedge clk);
        chk(irq_pin == 1, "R8 level asserted", irq_pin, 1);
        repeat (5) @(negedge clk);
        chk(irq_pin == 1, "R8 level held", irq_pin, 1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk(irq_sts == 0, "R7 irq_clr", irq_sts, 0);
        chk(irq_pin == 0, "R8 level released", irq_pin, 0);
        clr_all();

        // R10 active low level
        wr_cfg(EN | TST | 7'h0C | IEN);
        repeat (63) @(negedge clk);
        chk(irq_pin == 1, "R10 low idle", irq_pin, 1);
        @(negedge clk);
        chk(irq_pin == 0, "R10 low active", irq_pin, 0);
        clr_all();

        // R7 enable off: status set, pin idle
        wr_cfg(EN | TST | 7'h0C | HI);
        repeat (64) @(negedge clk);
        chk(irq_sts == 1, "R7 status without enable", irq_sts, 1);
        chk(irq_pin == 0, "R7 pin idle without enable", irq_pin, 0);
        clr_all();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule